// File: doc/BRIEF.md
# Two-Phase Clock Power Controller

This block turns one fast input clock into two complementary processor clock phases and runs the two power-saving modes of the core they feed. The decode stage shows each instruction word on `op_word` with a valid strobe and a read-phase strobe. When both strobes are high, the controller acts on three words and ignores all others. A stop word freezes both phases, holds the core and tells the external bus to go idle. It stays that way until an interrupt line has been low long enough to count as a real wake-up. A pair of rate words moves the phases between full speed and a sixteen-times slower rate.

When the emulation flag is high, the stop word is ignored, so the phases keep running for the debug logic. The stopped and slowed conditions are independent. A stop issued at the slow rate resumes at the slow rate. Interrupt pulse length is measured with the free-running input clock, because the phases produce no edges while they are frozen.

Top module: `tpc_power_ctl`

## Requirements
- R1: While reset is asserted, ph1 = 1, ph2 = 0, standby = 0 and bus_idle = 0. After reset the phases run at full rate.
- R2: ph2 is always the complement of ph1.
- R3: At full rate, ph1 changes level on every input clock cycle, so one ph1 period is 2 input clocks.
- R4: The word 32'h10800001 selects the slow rate, in which ph1 changes level every 16 input clocks (one ph1 period is 32 input clocks).
- R5: The word 32'h10800000 selects full rate again.
- R6: A word is acted on only when op_vld and op_rd are both high in the same cycle. Otherwise it has no effect.
- R7: With emu_mode = 0, the word 32'h06000001 stops the phases. They freeze with ph1 = 1 and ph2 = 0, and standby = 1 and bus_idle = 1 (hold address, float data, control strobes inactive) until the phases resume.
- R8: With emu_mode = 1, the stop word is ignored. The phases keep running and standby stays 0.
- R9: While stopped, a wake-up needs any irq_n line held low for at least two ph1 periods of the current rate, measured in input clocks (4 at full rate, 64 at slow rate). A shorter pulse leaves the phases frozen.
- R10: After a wake-up is recognised, the phases stay frozen for one more ph1 period (2 input clocks full, 32 slow) and then resume. standby and bus_idle clear when they resume.
- R11: A stop issued at the slow rate wakes with the slow threshold and resumes at the slow rate.
- R12: Words presented while the phases are stopped are ignored. A rate word given then does not change the rate after wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_n | input | 4 | Active-low external interrupt lines |
| emu_mode | input | 1 | Emulation flag; when high the stop word is ignored |
| op_word | input | 32 | Decoded instruction word |
| op_vld | input | 1 | op_word holds a valid instruction |
| op_rd | input | 1 | Instruction is in its read phase |
| ph1 | output | 1 | First clock phase |
| ph2 | output | 1 | Second clock phase, complement of ph1 |
| standby | output | 1 | Phases are frozen |
| bus_idle | output | 1 | External bus must hold address, float data and drive strobes inactive |

## Verification
The hardest state to reach from the ports is the frozen state at the slow rate, with an interrupt pulse one input clock short of the 64-cycle threshold. Reaching it needs a rate word, then a stop word, then a wait through a whole slow phase until ph1 freezes high. Only after that does a 63-cycle low pulse go out, followed by a 64-cycle pulse. The bench also sweeps every interrupt line at full rate, once just under the threshold and once exactly at it. It shows that the one-period restart delay holds the phases high for part of the wait, and that a rate word issued while frozen has no effect after wake-up.

// File: rtl/tpc_pkg.sv
`timescale 1ns/1ps
package tpc_pkg;

  localparam logic [31:0] OPC_STOP = 32'h0600_0001;
  localparam logic [31:0] OPC_SLOW = 32'h1080_0001;
  localparam logic [31:0] OPC_FULL = 32'h1080_0000;

  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_STOPPING = 2'd1,
    ST_STANDBY  = 2'd2,
    ST_RESTART  = 2'd3
  } pwr_state_t;

  typedef struct packed {
    logic stop;
    logic slow;
    logic full;
  } op_cmd_t;

endpackage

// File: rtl/tpc_decode.sv
`timescale 1ns/1ps
module tpc_decode
  import tpc_pkg::*;
(
  input  logic [31:0] op_word,
  input  logic        op_vld,
  input  logic        op_rd,
  input  logic        accept,
  output op_cmd_t     cmd
);

  logic fire;

  always_comb begin
    fire     = op_vld & op_rd & accept;
    cmd.stop = fire & (op_word == OPC_STOP);
    cmd.slow = fire & (op_word == OPC_SLOW);
    cmd.full = fire & (op_word == OPC_FULL);
  end

endmodule

// File: rtl/tpc_rate_div.sv
`timescale 1ns/1ps
module tpc_rate_div #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slow,
  input  logic clr,
  output logic tick
);

  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST_SLOW = DW'(DIV - 1);
  localparam logic [DW-1:0] LAST_FULL = '0;

  logic [DW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] last;

  always_comb begin
    last = slow ? LAST_SLOW : LAST_FULL;
    tick = run && (cnt_q == last);
    if (clr || !run || tick) cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_SLOW_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && slow && !clr) |=> !tick); // R4

endmodule

// File: rtl/tpc_wake_filter.sv
`timescale 1ns/1ps
module tpc_wake_filter #(
  parameter int NIRQ = 4,
  parameter int CW   = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] irq_n,
  input  logic            arm,
  input  logic [CW-1:0]   limit,
  output logic            wake
);

  logic [NIRQ-1:0] sync0_q, sync1_q;
  logic            any_low;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync0_q <= '1;
      sync1_q <= '1;
    end else begin
      sync0_q <= irq_n;
      sync1_q <= sync0_q;
    end
  end

  always_comb begin
    any_low  = ~&sync1_q;
    at_limit = (cnt_q == limit - 1'b1);
    wake     = arm && any_low && at_limit;
    if (!arm || !any_low) cnt_d = '0;
    else if (at_limit)    cnt_d = cnt_q;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_WAKE_NEEDS_HELD_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(any_low)); // R9

endmodule

// File: rtl/tpc_phase_gen.sv
`timescale 1ns/1ps
module tpc_phase_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic ph1,
  output logic ph2
);

  logic ph1_q, ph1_d;
  logic ph2_q, ph2_d;

  always_comb begin
    ph1_d = ph1_q;
    ph2_d = ph2_q;
    if (tick) begin
      ph1_d = ~ph1_q;
      ph2_d = ph1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph1_q <= 1'b1;
      ph2_q <= 1'b0;
    end else begin
      ph1_q <= ph1_d;
      ph2_q <= ph2_d;
    end
  end

  assign ph1 = ph1_q;
  assign ph2 = ph2_q;

  AST_PHASE_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
    ph2_q == !ph1_q); // R2

  AST_TICK_FLIPS_PH1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (ph1_q != $past(ph1_q))); // R3

endmodule

// File: rtl/tpc_power_ctl.sv
`timescale 1ns/1ps
module tpc_power_ctl
  import tpc_pkg::*;
#(
  parameter int DIV       = 16,
  parameter int NIRQ      = 4,
  parameter int WAKE_PERS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] irq_n,
  input  logic            emu_mode,
  input  logic [31:0]     op_word,
  input  logic            op_vld,
  input  logic            op_rd,
  output logic            ph1,
  output logic            ph2,
  output logic            standby,
  output logic            bus_idle
);

  localparam int PER_FULL  = 2;
  localparam int PER_SLOW  = 2 * DIV;
  localparam int WAKE_FULL = WAKE_PERS * PER_FULL;
  localparam int WAKE_SLOW = WAKE_PERS * PER_SLOW;
  localparam int CW        = $clog2(WAKE_SLOW + 1);

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_l = rst_sync_q[1];

  pwr_state_t    state_q, state_d;
  logic          slow_q, slow_d;
  logic [CW-1:0] rcnt_q, rcnt_d;
  op_cmd_t       cmd;
  logic          tick, run, rate_clr, wake;
  logic [CW-1:0] wake_lim, per_lim;

  tpc_decode u_decode (
    .op_word (op_word),
    .op_vld  (op_vld),
    .op_rd   (op_rd),
    .accept  (state_q == ST_RUN),
    .cmd     (cmd)
  );

  assign run      = (state_q == ST_RUN) || (state_q == ST_STOPPING);
  assign rate_clr = cmd.slow || cmd.full;

  tpc_rate_div #(.DIV(DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_l),
    .run   (run),
    .slow  (slow_q),
    .clr   (rate_clr),
    .tick  (tick)
  );

  assign wake_lim = slow_q ? CW'(WAKE_SLOW) : CW'(WAKE_FULL);
  assign per_lim  = slow_q ? CW'(PER_SLOW)  : CW'(PER_FULL);

  tpc_wake_filter #(.NIRQ(NIRQ), .CW(CW)) u_wake (
    .clk   (clk),
    .rst_n (rst_l),
    .irq_n (irq_n),
    .arm   (state_q == ST_STANDBY),
    .limit (wake_lim),
    .wake  (wake)
  );

  tpc_phase_gen u_phase (
    .clk   (clk),
    .rst_n (rst_l),
    .tick  (tick),
    .ph1   (ph1),
    .ph2   (ph2)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    slow_d  = slow_q;
    rcnt_d  = '0;
    if (cmd.slow) slow_d = 1'b1;
    if (cmd.full) slow_d = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (cmd.stop && !emu_mode) state_d = ST_STOPPING;
      end
      ST_STOPPING: begin
        // freeze on the edge that drives ph1 high
        if (tick && !ph1) state_d = ST_STANDBY;
      end
      ST_STANDBY: begin
        if (wake) state_d = ST_RESTART;
      end
      ST_RESTART: begin
        if (rcnt_q == per_lim - 1'b1) state_d = ST_RUN;
        else                          rcnt_d  = rcnt_q + 1'b1;
      end
      default: state_d = ST_RUN;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      state_q <= ST_RUN;
      slow_q  <= 1'b0;
      rcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      slow_q  <= slow_d;
      rcnt_q  <= rcnt_d;
    end
  end

  assign standby  = (state_q == ST_STANDBY) || (state_q == ST_RESTART);
  assign bus_idle = standby;

  AST_STANDBY_PHASE_LEVEL: assert property (@(posedge clk) disable iff (!rst_l)
    standby |-> (ph1 && !ph2)); // R7

  AST_STANDBY_NO_TICK: assert property (@(posedge clk) disable iff (!rst_l)
    standby |-> !tick); // R7

  AST_EMU_KEEPS_RUNNING: assert property (@(posedge clk) disable iff (!rst_l)
    (state_q == ST_RUN && emu_mode && op_vld && op_rd && op_word == OPC_STOP)
      |=> (state_q == ST_RUN)); // R8

  AST_STAY_STOPPED_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_l)
    (state_q == ST_STANDBY && (&irq_n) && $stable(irq_n)) |=> standby); // R9

  AST_RATE_HELD_WHILE_STOPPED: assert property (@(posedge clk) disable iff (!rst_l)
    (standby && $past(standby)) |-> $stable(slow_q)); // R12

endmodule

// File: tb/tb_tpc_power_ctl.sv
`timescale 1ns/1ps
module tb_tpc_power_ctl;

  logic        clk;
  logic        rst_n;
  logic [3:0]  irq_n;
  logic        emu_mode;
  logic [31:0] op_word;
  logic        op_vld, op_rd;
  logic        ph1, ph2, standby, bus_idle;

  int n_tests = 0;
  int n_fail  = 0;

  tpc_power_ctl dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_n    (irq_n),
    .emu_mode (emu_mode),
    .op_word  (op_word),
    .op_vld   (op_vld),
    .op_rd    (op_rd),
    .ph1      (ph1),
    .ph2      (ph2),
    .standby  (standby),
    .bus_idle (bus_idle)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w, input logic v, input logic r);
    @(negedge clk);
    op_word = w; op_vld = v; op_rd = r;
    @(negedge clk);
    op_word = '0; op_vld = 1'b0; op_rd = 1'b0;
  endtask

  // input clocks between two successive ph1 level changes
  task automatic interval(output int n);
    logic p;
    int   k;
    p = ph1; k = 0;
    while (ph1 == p && k < 100) begin @(negedge clk); k++; end
    p = ph1; n = 0;
    while (ph1 == p && n < 100) begin @(negedge clk); n++; end
  endtask

  task automatic rate_is(input int exp, input string req);
    int a, b;
    interval(a);
    interval(b);
    chk(a == exp && b == exp, req, b, exp);
  endtask

  task automatic wait_standby(input int lim);
    for (int k = 0; k < lim && !standby; k++) @(negedge clk);
  endtask

  task automatic pulse(input int line, input int len);
    @(negedge clk);
    irq_n[line] = 1'b0;
    repeat (len) @(negedge clk);
    irq_n[line] = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int mism;
    rst_n = 1'b0; irq_n = '1; emu_mode = 1'b0;
    op_word = '0; op_vld = 1'b0; op_rd = 1'b0;
    repeat (3) @(negedge clk);
    chk(ph1 == 1 && ph2 == 0, "R1 phases in reset", {ph1, ph2}, 2);
    chk(standby == 0 && bus_idle == 0, "R1 status in reset", {standby, bus_idle}, 0);
    rst_n = 1'b1;
    rate_is(1, "R1 R3 full rate after reset");

    mism = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (ph2 != !ph1) mism++;
    end
    chk(mism == 0, "R2 complement", mism, 0);

    // R6: strobes incomplete
    send(32'h1080_0001, 1'b1, 1'b0);
    rate_is(1, "R6 no read strobe");
    send(32'h1080_0001, 1'b0, 1'b1);
    rate_is(1, "R6 no valid strobe");

    send(32'h1080_0001, 1'b1, 1'b1);
    rate_is(16, "R4 slow rate");
    send(32'h1080_0000, 1'b1, 1'b1);
    rate_is(1, "R5 back to full");

    // R8: stop in emulation mode
    emu_mode = 1'b1;
    send(32'h0600_0001, 1'b1, 1'b1);
    repeat (10) @(negedge clk);
    chk(standby == 0, "R8 no standby in emulation", standby, 0);
    rate_is(1, "R8 phases keep running");
    emu_mode = 1'b0;

    // full-rate sweep over the interrupt lines
    for (int line = 0; line < 4; line++) begin
      send(32'h0600_0001, 1'b1, 1'b1);
      wait_standby(20);
      chk(standby == 1 && bus_idle == 1, "R7 standby and bus idle", {standby, bus_idle}, 3);
      chk(ph1 == 1 && ph2 == 0, "R7 frozen level", {ph1, ph2}, 2);
      send(32'h1080_0001, 1'b1, 1'b1);
      pulse(line, 3);
      repeat (10) @(negedge clk);
      chk(standby == 1 && ph1 == 1, "R9 short pulse ignored", standby, 1);
      pulse(line, 4);
      chk(standby == 1 && ph1 == 1, "R10 still frozen during restart delay", standby, 1);
      repeat (20) @(negedge clk);
      chk(standby == 0 && bus_idle == 0, "R10 resumed", {standby, bus_idle}, 0);
      rate_is(1, "R12 rate word while stopped ignored");
    end

    // slow-rate stop
    send(32'h1080_0001, 1'b1, 1'b1);
    send(32'h0600_0001, 1'b1, 1'b1);
    wait_standby(80);
    chk(standby == 1 && ph1 == 1 && ph2 == 0, "R7 R11 frozen at slow rate", {ph1, ph2}, 2);
    pulse(2, 63);
    repeat (40) @(negedge clk);
    chk(standby == 1 && ph1 == 1, "R9 R11 63-clock pulse ignored", standby, 1);
    pulse(2, 64);
    repeat (20) @(negedge clk);
    chk(standby == 1 && ph1 == 1, "R10 R11 slow restart delay", standby, 1);
    repeat (60) @(negedge clk);
    chk(standby == 0, "R11 resumed", standby, 0);
    rate_is(16, "R11 resumes at slow rate");
    send(32'h1080_0000, 1'b1, 1'b1);
    rate_is(1, "R5 full after slow wake");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule